// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Checker

This block sits beside an SDRAM command bus and watches it. On every rising clock edge it turns the four control strobes into one decoded command. It tracks the state of every bank and of the device's low-power modes, and judges whether the command may be issued at that moment. Only the command lines are observed. The memory array and the data path are not modelled.

Each bank is idle, open (activated), refreshing or mode-busy. The device as a whole is either running normally, powered down or in self-refresh. The timing limits are module parameters counted in clock cycles:

- row-cycle time after a refresh (`TRC`)
- activate-to-access delay (`TRCD`)
- minimum open time before a precharge (`TRAS`)
- spacing between activates to different banks (`TRRD`)

A command that breaks a rule raises a one-cycle flag and leaves all tracked state unchanged. A monitor or a controller self-check can use the three registered outputs directly.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With `cs_n` low, the strobes {`ras_n`,`cas_n`,`we_n`} decode as follows: 000 mode set (code 2), 001 refresh (3), 010 precharge (4), 011 activate (5), 100 write (6), 101 read (7), 110 burst stop (8), 111 no-op (1). With `cs_n` high the command is deselect (0). `cmd_o` shows the code one clock after the edge that sampled the strobes, and it is 0 during reset.
- R2: `ap_o` is high in the same cycle as `cmd_o` exactly when the command was a read or write with `addr_ap` high.
- R3: `illegal_o` is high for one cycle after each rejected command and low otherwise. A rejected command changes no bank, timer or power state.
- R4: Mode set and refresh are accepted only when every bank is idle.
- R5: A refresh with `cke` high puts all banks in the refreshing state. Every command other than no-op or deselect is rejected on the next `TRC`-1 edges, and accepted again from the `TRC`-th edge after the refresh.
- R6: After an accepted mode set, every command other than no-op or deselect is rejected on the next edge only.
- R7: An activate is accepted only on an idle bank. When the last accepted activate went to a different bank, fewer than `TRRD` edges ago, the activate is rejected.
- R8: A read or write is accepted only on an open bank, and only at least `TRCD` edges after that bank's activate.
- R9: A precharge on an idle bank is accepted and has no effect. On an open bank it is accepted only at least `TRAS` edges after the activate, and it makes the bank idle.
- R10: A refresh with `cke` low enters self-refresh. Until an edge with `cke` high ends it, every command other than no-op or deselect is rejected.
- R11: A no-op or deselect with `cke` low while all banks are idle enters power-down. Every command other than no-op or deselect is rejected until an edge with `cke` high ends power-down.
- R12: No-op and deselect are never rejected. A burst stop is rejected only in the busy or low-power states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable strobe |
| ba | input | BA_W | Bank select |
| addr_ap | input | 1 | Address bit that requests auto-precharge on accesses |
| cmd_o | output | 4 | Registered decoded command code |
| ap_o | output | 1 | Registered auto-precharge request |
| illegal_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
The most delicate coincidence is a busy window running out on the same edge that a new command arrives. The command must then see the banks as idle, not still refreshing or mode-busy. The bench steps activates through every cycle of the refresh and mode-set windows, right up to the first edge where they may be accepted. A second coincidence is a low-power exit on the edge that also carries a command: that command is still judged under low power. A reference model of the bank and power states, running beside the design, predicts the decision on every clock.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_REF   = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_WR    = 4'd6,
    CMD_RD    = 4'd7,
    CMD_BST   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_REFR = 2'd2,
    BK_MODE = 2'd3
  } bank_e;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_PDN  = 2'd1,
    LP_SREF = 2'd2
  } lp_e;

  // strobe pattern to command
  function automatic cmd_e decode_strobes(input logic cs_n, input logic ras_n,
                                          input logic cas_n, input logic we_n);
    if (cs_n) return CMD_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b000:  return CMD_MRS;
      3'b001:  return CMD_REF;
      3'b010:  return CMD_PRE;
      3'b011:  return CMD_ACT;
      3'b100:  return CMD_WR;
      3'b101:  return CMD_RD;
      3'b110:  return CMD_BST;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdcg_decode.sv
module sdcg_decode
  import sdcg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ap_bit,
  output cmd_e cmd,
  output logic ap_req,
  output logic quiet
);
  always_comb begin
    cmd    = decode_strobes(cs_n, ras_n, cas_n, we_n);
    ap_req = is_access(cmd) && ap_bit;
    quiet  = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  end
endmodule

// File: rtl/sdcg_busy_timer.sv
module sdcg_busy_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rem_q <= '0;
    else if (load)          rem_q <= load_val;
    else if (rem_q != '0)   rem_q <= rem_q - 1'b1;
  end

  assign busy = (rem_q != '0);
  assign done = (rem_q == CW'(1));
endmodule

// File: rtl/sdcg_bank.sv
module sdcg_bank
  import sdcg_pkg::*;
#(
  parameter int AGE_MAX = 5,
  parameter int AGE_W   = 3,
  parameter int TRCD    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_ref,
  input  logic             do_mrs,
  input  logic             busy_done,
  input  logic             rw_hit,
  output bank_e            state,
  output logic [AGE_W-1:0] age
);
  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
    return (a >= AGE_W'(AGE_MAX)) ? a : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      age   <= AGE_W'(AGE_MAX);
    end else begin
      age <= do_act ? AGE_W'(1) : age_step(age);
      if (do_act)      state <= BK_OPEN;
      else if (do_pre) state <= BK_IDLE;
      else if (do_ref) state <= BK_REFR;
      else if (do_mrs) state <= BK_MODE;
      else if (busy_done && (state == BK_REFR || state == BK_MODE)) state <= BK_IDLE;
    end
  end

  // a bank only opens from idle
  assert_open_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BK_OPEN && $past(state) != BK_OPEN) |-> $past(state) == BK_IDLE);

  // an accepted access never comes before the activate delay
  assert_access_after_rcd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rw_hit |-> (state == BK_OPEN && age >= AGE_W'(TRCD)));
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdcg_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int TRC  = 7,
  parameter int TRCD = 3,
  parameter int TRAS = 5,
  parameter int TRRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            addr_ap,
  output logic [3:0]      cmd_o,
  output logic            ap_o,
  output logic            illegal_o
);
  localparam int NB      = 1 << BA_W;
  localparam int AGE_MAX = (TRAS > TRCD) ? TRAS : TRCD;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int RRD_W   = $clog2(TRRD + 1);
  localparam int BT_W    = $clog2(TRC + 1);

  cmd_e cmd;
  logic ap_req, quiet;

  sdcg_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ap_bit(addr_ap), .cmd(cmd), .ap_req(ap_req), .quiet(quiet)
  );

  bank_e            bst  [NB];
  logic [AGE_W-1:0] bage [NB];
  logic [NB-1:0]    hit;
  logic             busy, busy_done;
  lp_e              lp_q;
  logic [RRD_W-1:0] rrd_q;
  logic [BA_W-1:0]  last_ba_q;

  logic all_idle, all_refr, all_mode;
  always_comb begin
    all_idle = 1'b1;
    all_refr = 1'b1;
    all_mode = 1'b1;
    for (int i = 0; i < NB; i++) begin
      all_idle &= (bst[i] == BK_IDLE);
      all_refr &= (bst[i] == BK_REFR);
      all_mode &= (bst[i] == BK_MODE);
    end
  end

  bank_e            tgt_st;
  logic [AGE_W-1:0] tgt_age;
  assign tgt_st  = bst[ba];
  assign tgt_age = bage[ba];

  function automatic logic rcd_met(input logic [AGE_W-1:0] a);
    return a >= AGE_W'(TRCD);
  endfunction
  function automatic logic ras_met(input logic [AGE_W-1:0] a);
    return a >= AGE_W'(TRAS);
  endfunction
  function automatic logic rrd_met(input logic [RRD_W-1:0] a, input logic same);
    return same || (a >= RRD_W'(TRRD));
  endfunction

  logic legal;
  always_comb begin
    legal = 1'b1;
    if (!quiet) begin
      if (lp_q != LP_NONE || busy) legal = 1'b0;
      else begin
        case (cmd)
          CMD_MRS, CMD_REF: legal = all_idle;
          CMD_ACT: legal = (tgt_st == BK_IDLE) && rrd_met(rrd_q, last_ba_q == ba);
          CMD_RD, CMD_WR: legal = (tgt_st == BK_OPEN) && rcd_met(tgt_age);
          CMD_PRE: legal = (tgt_st == BK_IDLE) || (tgt_st == BK_OPEN && ras_met(tgt_age));
          default: legal = 1'b1;
        endcase
      end
    end
  end

  // named internal events
  logic act_go, pre_go, rw_go, ref_go, sref_go, mrs_go, pdn_go;
  assign act_go  = legal && (cmd == CMD_ACT);
  assign pre_go  = legal && (cmd == CMD_PRE);
  assign rw_go   = legal && is_access(cmd);
  assign ref_go  = legal && (cmd == CMD_REF) && cke;
  assign sref_go = legal && (cmd == CMD_REF) && !cke;
  assign mrs_go  = legal && (cmd == CMD_MRS);
  assign pdn_go  = (lp_q == LP_NONE) && !cke && all_idle && quiet;

  sdcg_busy_timer #(.CW(BT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(ref_go || mrs_go),
    .load_val(ref_go ? BT_W'(TRC - 1) : BT_W'(1)),
    .busy(busy), .done(busy_done)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign hit[i] = (ba == BA_W'(i));
    sdcg_bank #(.AGE_MAX(AGE_MAX), .AGE_W(AGE_W), .TRCD(TRCD)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(act_go && hit[i]), .do_pre(pre_go && hit[i]),
      .do_ref(ref_go), .do_mrs(mrs_go), .busy_done(busy_done),
      .rw_hit(rw_go && hit[i]), .state(bst[i]), .age(bage[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q      <= LP_NONE;
      rrd_q     <= RRD_W'(TRRD);
      last_ba_q <= '0;
      cmd_o     <= 4'(CMD_DESEL);
      ap_o      <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      if (lp_q != LP_NONE) begin
        if (cke) lp_q <= LP_NONE;
      end else if (sref_go) lp_q <= LP_SREF;
      else if (pdn_go)      lp_q <= LP_PDN;
      if (act_go) begin
        rrd_q     <= RRD_W'(1);
        last_ba_q <= ba;
      end else if (rrd_q < RRD_W'(TRRD)) rrd_q <= rrd_q + 1'b1;
      cmd_o     <= 4'(cmd);
      ap_o      <= ap_req;
      illegal_o <= !legal;
    end
  end

  assert_ap_on_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ap_o |-> (cmd_o == 4'(CMD_RD) || cmd_o == 4'(CMD_WR)));

  assert_quiet_never_flagged_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (cmd_o != 4'(CMD_NOP) && cmd_o != 4'(CMD_DESEL)));

  assert_ref_fills_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |=> all_refr);

  assert_busy_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !quiet) |=> illegal_o);

  assert_mrs_fills_banks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_go |=> all_mode);

  assert_mode_idle_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && (cmd == CMD_MRS || cmd == CMD_REF) && !all_idle) |=> illegal_o);
endmodule

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;
  localparam int TRC = 7, TRCD = 3, TRAS = 5, TRRD = 2;
  localparam int AMAX = (TRAS > TRCD) ? TRAS : TRCD;
  localparam int K_DESEL = 0, K_NOP = 1, K_MRS = 2, K_REF = 3, K_PRE = 4,
                 K_ACT = 5, K_WR = 6, K_RD = 7, K_BST = 8;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic addr_ap = 1'b0;
  logic [3:0] cmd_o;
  logic ap_o, illegal_o;

  always #10 clk = ~clk;

  sdram_cmd_guard #(.BA_W(2), .TRC(TRC), .TRCD(TRCD), .TRAS(TRAS), .TRRD(TRRD)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr_ap(addr_ap), .cmd_o(cmd_o), .ap_o(ap_o), .illegal_o(illegal_o)
  );

  int n_chk = 0, n_fail = 0;
  bit chk_en = 0, finished = 0;

  // reference model state
  int m_st[4], m_age[4], m_rrd, m_last, m_rem, m_kind, m_lp;
  int e_cmd = 0, e_ap = 0, e_ill = 0;
  string e_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_st[b]) begin m_st[b] = 0; m_age[b] = AMAX; end
      m_rrd = TRRD; m_last = 0; m_rem = 0; m_kind = 0; m_lp = 0;
      e_cmd = 0; e_ap = 0; e_ill = 0; e_tag = "R3";
    end else begin
      int c, b;
      bit ok, idle_all;
      b = int'(ba);
      if (cs_n) c = K_DESEL;
      else case ({ras_n, cas_n, we_n})
        3'b000: c = K_MRS;  3'b001: c = K_REF;
        3'b010: c = K_PRE;  3'b011: c = K_ACT;
        3'b100: c = K_WR;   3'b101: c = K_RD;
        3'b110: c = K_BST;  default: c = K_NOP;
      endcase
      e_cmd = c;
      e_ap = ((c == K_RD || c == K_WR) && addr_ap) ? 1 : 0;
      idle_all = 1;
      foreach (m_st[i]) if (m_st[i] != 0) idle_all = 0;
      ok = 1; e_tag = "R12";
      if (c != K_NOP && c != K_DESEL) begin
        if (m_lp == 1) begin ok = 0; e_tag = "R11"; end
        else if (m_lp == 2) begin ok = 0; e_tag = "R10"; end
        else if (m_rem > 0) begin ok = 0; e_tag = (m_kind == 3) ? "R6" : "R5"; end
        else case (c)
          K_MRS, K_REF: begin ok = idle_all; e_tag = "R4"; end
          K_ACT: begin ok = (m_st[b] == 0) && (m_rrd >= TRRD || m_last == b); e_tag = "R7"; end
          K_RD, K_WR: begin ok = (m_st[b] == 1) && (m_age[b] >= TRCD); e_tag = "R8"; end
          K_PRE: begin ok = (m_st[b] == 0) || (m_st[b] == 1 && m_age[b] >= TRAS); e_tag = "R9"; end
          default: ok = 1;
        endcase
      end
      e_ill = ok ? 0 : 1;
      foreach (m_age[i]) if (m_age[i] < AMAX) m_age[i]++;
      if (m_rrd < TRRD) m_rrd++;
      if (m_rem > 0) begin
        if (m_rem == 1) foreach (m_st[i]) if (m_st[i] >= 2) m_st[i] = 0;
        m_rem--;
      end
      if (m_lp != 0) begin
        if (cke) m_lp = 0;
      end else if (ok) begin
        case (c)
          K_ACT: begin m_st[b] = 1; m_age[b] = 1; m_rrd = 1; m_last = b; end
          K_PRE: m_st[b] = 0;
          K_MRS: begin foreach (m_st[i]) m_st[i] = 3; m_rem = 1; m_kind = 3; end
          K_REF: if (cke) begin foreach (m_st[i]) m_st[i] = 2; m_rem = TRC - 1; m_kind = 2; end
                 else m_lp = 2;
          K_NOP, K_DESEL: if (!cke && idle_all) m_lp = 1;
          default: ;
        endcase
      end
    end
  end

  task automatic check_one(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    if (!chk_en) return;
    check_one("R1", int'(cmd_o), e_cmd);
    check_one("R2", int'(ap_o), e_ap);
    check_one(e_tag, int'(illegal_o), e_ill);
  endtask

  task automatic issue(input int kind, input int b, input bit ap, input bit ck);
    @(negedge clk);
    check_all();
    cke = ck; ba = 2'(b); addr_ap = ap;
    cs_n = (kind == K_DESEL);
    case (kind)
      K_MRS: {ras_n, cas_n, we_n} = 3'b000;
      K_REF: {ras_n, cas_n, we_n} = 3'b001;
      K_PRE: {ras_n, cas_n, we_n} = 3'b010;
      K_ACT: {ras_n, cas_n, we_n} = 3'b011;
      K_WR:  {ras_n, cas_n, we_n} = 3'b100;
      K_RD:  {ras_n, cas_n, we_n} = 3'b101;
      K_BST: {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    chk_en = 1;
    issue(K_DESEL, 0, 0, 1);   // R3 reset state compared here
    rst_n = 1'b1;
    // R1 R12 decode of quiet and burst stop
    issue(K_DESEL, 0, 0, 1); issue(K_NOP, 0, 0, 1); issue(K_BST, 1, 0, 1);
    // R6 mode set then immediate activate rejected, next accepted
    issue(K_MRS, 0, 0, 1); issue(K_ACT, 0, 0, 1); issue(K_ACT, 0, 0, 1);
    // R7 spacing to another bank, reopen of open bank
    issue(K_ACT, 1, 0, 1); issue(K_ACT, 1, 0, 1); issue(K_ACT, 0, 0, 1);
    // R8 R2 accesses
    issue(K_RD, 0, 1, 1); issue(K_RD, 1, 0, 1); issue(K_WR, 2, 1, 1);
    // R9 early precharge; R4 mode/refresh with banks open
    issue(K_PRE, 1, 0, 1); issue(K_MRS, 0, 0, 1); issue(K_REF, 0, 0, 1);
    nops(3);
    issue(K_PRE, 1, 0, 1); issue(K_PRE, 0, 0, 1); issue(K_PRE, 3, 0, 1);
    issue(K_WR, 1, 1, 1);
    // R5 refresh window walked to its end
    issue(K_REF, 0, 0, 1);
    for (int i = 0; i < TRC; i++) issue(K_ACT, 2, 0, 1);
    nops(5); issue(K_PRE, 2, 0, 1);
    // R11 power-down entry, rejected command, exit with a command
    issue(K_NOP, 0, 0, 0); issue(K_NOP, 0, 0, 0); issue(K_ACT, 0, 0, 0);
    issue(K_ACT, 0, 0, 1); issue(K_ACT, 0, 0, 1);
    nops(3); issue(K_RD, 0, 0, 1); issue(K_WR, 0, 1, 1);
    nops(2); issue(K_PRE, 0, 0, 1);
    // R10 self-refresh
    issue(K_REF, 0, 0, 0); issue(K_NOP, 0, 0, 0); issue(K_RD, 1, 0, 0);
    issue(K_BST, 0, 0, 0); issue(K_NOP, 0, 0, 1);
    issue(K_REF, 0, 0, 1); nops(TRC + 1);
    issue(K_MRS, 0, 0, 1); issue(K_ACT, 3, 0, 1); issue(K_ACT, 3, 1, 1);
    issue(K_BST, 3, 0, 1); issue(K_DESEL, 0, 0, 1);
    issue(K_NOP, 0, 0, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule